// File: doc/BRIEF.md
# Interrupt Redistributor Sleep Handshake Controller

This block sits between an interrupt routing unit and the interrupt interface of one processor core. It owns a single 32-bit control word for that core. Software sets a sleep bit in it before the core is powered down and clears the bit after power-up. Each change of the sleep bit starts a short command/acknowledge exchange with the downstream core interface. Entering sleep sends a release command and then a quiesce command. Leaving sleep sends a link-enable command. A read-only status bit reports when the downstream link has acknowledged the quiesce.

While the sleep bit is set, or the link is not fully awake, arriving interrupts are not forwarded. They are accepted into a local hold queue, and a wake request to the power controller is raised. Once the link is awake again, the held interrupts are forwarded first, in the order they arrived, and only then do newer ones follow. Access to the control word depends on security state. With the global security-disable input high, any access works. With it low, non-secure reads return zero and non-secure writes do nothing.

Both interrupt paths are valid/ready streams. An upstream source must hold `irq_in_valid` and `irq_in_id` until `irq_in_ready` is seen high. The output holds `irq_out_valid` and `irq_out_id` steady while `irq_out_ready` is low. The one exception is the cycle in which a sleep request is accepted: the offered interrupt is then withdrawn and stays upstream.

Top module: `rdist_sleep_ctrl`

## Requirements
- R1: After reset the control word at byte offset 0x14 reads 0x00000006, with link-asleep status (bit 2) = 1 and sleep (bit 1) = 1. In this state `wake_req`, `cmd_valid` and `proto_err` are 0.
- R2: Bits 31 and 0 are plain read/write storage that resets to 0. Bits 30:3 read 0 and ignore writes, and bit 2 ignores writes. Any other offset reads 0, and a write to it changes nothing.
- R3: With `sec_disable`=0, a non-secure read returns 0 and a non-secure write has no effect. With `sec_disable`=1, non-secure accesses behave like secure ones.
- R4: Writing bit 1 = 1 while awake makes `cmd_valid` pulse one cycle later with `cmd_code`=1 (release). The first `cmd_ack` after that gives a pulse with `cmd_code`=2 (quiesce) in the next cycle. The second `cmd_ack` sets bit 2 in the next cycle.
- R5: Writing bit 1 = 0 while asleep makes bits 2 and 1 read 0 from the next cycle. In that same cycle `cmd_valid` pulses with `cmd_code`=3 (link enable). The link counts as awake from the cycle after the matching `cmd_ack`.
- R6: Unless the link is awake, `irq_out_valid` stays 0. Arriving interrupts are then accepted into the hold queue while it has room.
- R7: An interrupt accepted while bit 1 reads 1 drives `wake_req` high from the next cycle. `wake_req` stays high until a write that clears bit 1 is accepted, and is low from the cycle after that write.
- R8: When the link is awake and the hold queue is empty, input passes straight through to the output. Otherwise held interrupts leave in arrival order, ahead of any newer ones.
- R9: With the hold queue full and the link not passing through, `irq_in_ready` is 0. A stalled output keeps `irq_out_valid` and `irq_out_id` stable.
- R10: Writing bit 1 = 0 while the quiesce exchange is still in progress is a protocol error. `proto_err` pulses for one cycle, the next cycle. Bit 1 stays 1 and the exchange continues. Writing bit 1 = 1 while the link is being re-enabled is ignored without an error.
- R11: `cmd_ack` while the link is awake or fully asleep changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset in the per-core frame |
| reg_wdata | input | 32 | Write data |
| reg_nonsec | input | 1 | Access is non-secure |
| sec_disable | input | 1 | Global security disable |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| irq_in_valid | input | 1 | Arriving interrupt offered |
| irq_in_id | input | ID_W | Arriving interrupt number |
| irq_in_ready | output | 1 | Arriving interrupt accepted |
| irq_out_valid | output | 1 | Interrupt offered to the core interface |
| irq_out_id | output | ID_W | Forwarded interrupt number |
| irq_out_ready | input | 1 | Core interface takes the interrupt |
| wake_req | output | 1 | Wake request to power control |
| cmd_valid | output | 1 | One-cycle command pulse to the core interface |
| cmd_code | output | 2 | 1 release, 2 quiesce, 3 link enable |
| cmd_ack | input | 1 | Acknowledge pulse for the outstanding command |
| proto_err | output | 1 | Illegal wake attempt during quiesce |

## Verification
The assertions assume that the upstream source keeps an offered interrupt and its number steady until it is accepted. They also assume that the core interface returns exactly one acknowledge pulse per command, possibly in the same cycle as the command. The bench's send task holds valid and id until it sees ready before the clock edge. Its acknowledge responder answers each observed command pulse once, after a fixed latency, and the only stray acknowledges are injected while the link is awake or asleep. Output back-pressure is exercised with a pseudo-random ready pattern.

// File: rtl/rdsc_pkg.sv
`timescale 1ns/1ps
package rdsc_pkg;
  typedef enum logic [1:0] {
    LNK_AWAKE     = 2'd0,
    LNK_QUIESCING = 2'd1,
    LNK_ASLEEP    = 2'd2,
    LNK_WAKING    = 2'd3
  } lnk_state_t;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_RELEASE = 2'd1,
    CMD_QUIESCE = 2'd2,
    CMD_ENABLE  = 2'd3
  } link_cmd_t;

  localparam int WORD_W      = 32;
  localparam int BIT_IMPL_HI = 31;
  localparam int BIT_ASLEEP  = 2;
  localparam int BIT_SLEEP   = 1;
  localparam int BIT_IMPL_LO = 0;
endpackage

// File: rtl/rdsc_regif.sv
`timescale 1ns/1ps
module rdsc_regif
  import rdsc_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] WAKER_OFFSET = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_nonsec,
  input  logic              sec_disable,
  input  logic              sleep_bit,
  input  logic              asleep_bit,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              wr_sleep,
  output logic              wr_sleep_val
);
  logic hit, allowed, wr_en, rd_en;
  logic impl_hi, impl_lo;
  logic [WORD_W-1:0] word;
  logic unused_wdata;

  assign hit     = reg_valid && (reg_addr == WAKER_OFFSET);
  assign allowed = sec_disable || !reg_nonsec;
  assign wr_en   = hit && reg_write && allowed;
  assign rd_en   = hit && !reg_write && allowed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      impl_hi <= 1'b0;
      impl_lo <= 1'b0;
    end else if (wr_en) begin
      impl_hi <= reg_wdata[BIT_IMPL_HI];
      impl_lo <= reg_wdata[BIT_IMPL_LO];
    end
  end

  always_comb begin
    word              = '0;
    word[BIT_IMPL_HI] = impl_hi;
    word[BIT_ASLEEP]  = asleep_bit;
    word[BIT_SLEEP]   = sleep_bit;
    word[BIT_IMPL_LO] = impl_lo;
  end

  assign reg_rdata    = rd_en ? word : '0;
  assign wr_sleep     = wr_en;
  assign wr_sleep_val = reg_wdata[BIT_SLEEP];
  assign unused_wdata = ^reg_wdata[BIT_IMPL_HI-1:BIT_ASLEEP];
endmodule

// File: rtl/rdsc_link_fsm.sv
`timescale 1ns/1ps
module rdsc_link_fsm
  import rdsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sleep,
  input  logic       wr_sleep_val,
  input  logic       cmd_ack,
  output lnk_state_t lnk_state,
  output logic       sleep_bit,
  output logic       asleep_bit,
  output logic       sleep_go,
  output logic       wake_go,
  output logic       cmd_valid,
  output logic [1:0] cmd_code,
  output logic       proto_err
);
  lnk_state_t state_q, state_d;
  logic       phase_q, phase_d;
  logic       issue_d;
  link_cmd_t  code_q, code_d;
  logic       issue_q, err_q;
  logic       bad_clear;

  assign sleep_go  = wr_sleep &&  wr_sleep_val && (state_q == LNK_AWAKE);
  assign wake_go   = wr_sleep && !wr_sleep_val && (state_q == LNK_ASLEEP);
  assign bad_clear = wr_sleep && !wr_sleep_val && (state_q == LNK_QUIESCING);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    issue_d = 1'b0;
    code_d  = code_q;
    unique case (state_q)
      LNK_AWAKE: if (sleep_go) begin
        state_d = LNK_QUIESCING;
        phase_d = 1'b0;
        issue_d = 1'b1;
        code_d  = CMD_RELEASE;
      end
      LNK_QUIESCING: if (cmd_ack) begin
        if (!phase_q) begin
          phase_d = 1'b1;
          issue_d = 1'b1;
          code_d  = CMD_QUIESCE;
        end else begin
          state_d = LNK_ASLEEP;
        end
      end
      LNK_ASLEEP: if (wake_go) begin
        state_d = LNK_WAKING;
        issue_d = 1'b1;
        code_d  = CMD_ENABLE;
      end
      LNK_WAKING: if (cmd_ack) state_d = LNK_AWAKE;
      default: state_d = LNK_ASLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LNK_ASLEEP;
      phase_q <= 1'b0;
      issue_q <= 1'b0;
      code_q  <= CMD_NONE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      issue_q <= issue_d;
      code_q  <= code_d;
      err_q   <= bad_clear;
    end
  end

  assign lnk_state  = state_q;
  assign sleep_bit  = (state_q == LNK_QUIESCING) || (state_q == LNK_ASLEEP);
  assign asleep_bit = (state_q == LNK_ASLEEP);
  assign cmd_valid  = issue_q;
  assign cmd_code   = code_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/rdsc_hold_fifo.sv
`timescale 1ns/1ps
module rdsc_hold_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/rdist_sleep_ctrl.sv
`timescale 1ns/1ps
module rdist_sleep_ctrl
  import rdsc_pkg::*;
#(
  parameter int                ID_W         = 10,
  parameter int                HOLD_DEPTH   = 8,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] WAKER_OFFSET = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_nonsec,
  input  logic              sec_disable,
  output logic [31:0]       reg_rdata,
  input  logic              irq_in_valid,
  input  logic [ID_W-1:0]   irq_in_id,
  output logic              irq_in_ready,
  output logic              irq_out_valid,
  output logic [ID_W-1:0]   irq_out_id,
  input  logic              irq_out_ready,
  output logic              wake_req,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  input  logic              cmd_ack,
  output logic              proto_err
);
  lnk_state_t lnk_state;
  logic sleep_bit, asleep_bit, sleep_go, wake_go;
  logic wr_sleep, wr_sleep_val;
  logic awake, bypass, accept, push, pop, q_empty, q_full;
  logic [ID_W-1:0] q_head;
  logic wake_q;

  rdsc_regif #(.ADDR_W(ADDR_W), .WAKER_OFFSET(WAKER_OFFSET)) u_regif (
    .clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_wdata,
    .reg_nonsec, .sec_disable, .sleep_bit, .asleep_bit,
    .reg_rdata, .wr_sleep, .wr_sleep_val
  );

  rdsc_link_fsm u_fsm (
    .clk, .rst_n, .wr_sleep, .wr_sleep_val, .cmd_ack,
    .lnk_state, .sleep_bit, .asleep_bit, .sleep_go, .wake_go,
    .cmd_valid, .cmd_code, .proto_err
  );

  rdsc_hold_fifo #(.DEPTH(HOLD_DEPTH), .W(ID_W)) u_hold (
    .clk, .rst_n, .push, .push_data(irq_in_id), .pop,
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  assign awake         = (lnk_state == LNK_AWAKE);
  assign bypass        = awake && q_empty;
  assign irq_out_valid = awake && (!q_empty || irq_in_valid);
  assign irq_out_id    = q_empty ? irq_in_id : q_head;
  assign irq_in_ready  = bypass ? irq_out_ready : !q_full;
  assign accept        = irq_in_valid && irq_in_ready;
  assign push          = accept && !bypass;
  assign pop           = awake && !q_empty && irq_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                     wake_q <= 1'b0;
    else if (wake_go)               wake_q <= 1'b0;
    else if (accept && sleep_bit)   wake_q <= 1'b1;
  end
  assign wake_req = wake_q;
endmodule

// File: rtl/rdsc_checker.sv
`timescale 1ns/1ps
module rdsc_checker
  import rdsc_pkg::*;
#(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ack,
  input logic            irq_out_valid,
  input logic            irq_out_ready,
  input logic [ID_W-1:0] irq_out_id,
  input logic            wake_req,
  input logic            wake_go,
  input logic            sleep_go,
  input lnk_state_t      lnk_state,
  input logic            asleep_bit,
  input logic            proto_err,
  input logic            reg_valid,
  input logic            reg_write,
  input logic            reg_nonsec,
  input logic            sec_disable,
  input logic [31:0]     reg_rdata
);
  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> !cmd_valid);

  assert_asleep_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_bit) |-> $past(cmd_ack));

  assert_hold_while_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_state != LNK_AWAKE) |-> !irq_out_valid);

  assert_wake_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> $past(wake_go));

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out_valid && !irq_out_ready && !sleep_go |=> irq_out_valid && $stable(irq_out_id));

  assert_err_only_quiescing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(lnk_state) == LNK_QUIESCING);

  assert_nonsec_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && reg_nonsec && !sec_disable |-> reg_rdata == 32'd0);
endmodule

bind rdist_sleep_ctrl rdsc_checker #(.ID_W(ID_W)) u_chk (.*);

// File: tb/rdist_sleep_ctrl_test.sv
`timescale 1ns/1ps
module rdist_sleep_ctrl_test;
  localparam int ID_W  = 10;
  localparam int DEPTH = 8;
  localparam logic [15:0] OFS = 16'h0014;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0, reg_nonsec = 1'b0, sec_disable = 1'b1;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_in_valid = 1'b0;
  logic [ID_W-1:0] irq_in_id = '0;
  logic irq_in_ready, irq_out_valid, irq_out_ready;
  logic [ID_W-1:0] irq_out_id;
  logic wake_req, cmd_valid, cmd_ack = 1'b0, proto_err;
  logic [1:0] cmd_code;

  int total = 0, bad = 0;
  bit auto_ack = 0, rdy_rand = 0;
  int ack_lat = 2;

  always #4 clk = ~clk;

  rdist_sleep_ctrl #(.ID_W(ID_W), .HOLD_DEPTH(DEPTH)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ms;               // 0 awake, 1 quiescing, 2 asleep, 3 waking
  int ph;
  bit m_issue, m_wake, m_err, m_b31, m_b0;
  int m_code;
  int unsigned hq[$];

  function automatic bit m_in_ready();
    if (ms == 0 && hq.size() == 0) return irq_out_ready;
    return hq.size() < DEPTH;
  endfunction

  function automatic logic [31:0] m_rdata();
    if (reg_valid && !reg_write && reg_addr == OFS && (sec_disable || !reg_nonsec))
      return {m_b31, 28'd0, ms == 2, (ms == 1 || ms == 2), m_b0};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 2; ph = 0; m_issue = 0; m_wake = 0; m_err = 0; m_b31 = 0; m_b0 = 0; m_code = 0;
      hq.delete();
    end else begin
      bit wr_ok, acc, byp, popq, pushq, ps;
      wr_ok = reg_valid && reg_write && reg_addr == OFS && (sec_disable || !reg_nonsec);
      acc   = irq_in_valid && m_in_ready();
      byp   = (ms == 0) && hq.size() == 0;
      popq  = (ms == 0) && hq.size() > 0 && irq_out_ready;
      pushq = acc && !byp;
      ps    = (ms == 1 || ms == 2);
      if (wr_ok && !reg_wdata[1] && ms == 2) m_wake = 0;
      else if (acc && ps) m_wake = 1;
      m_err = wr_ok && !reg_wdata[1] && ms == 1;
      m_issue = 0;
      case (ms)
        0: if (wr_ok && reg_wdata[1]) begin ms = 1; ph = 0; m_issue = 1; m_code = 1; end
        1: if (cmd_ack) begin
             if (ph == 0) begin ph = 1; m_issue = 1; m_code = 2; end
             else ms = 2;
           end
        2: if (wr_ok && !reg_wdata[1]) begin ms = 3; m_issue = 1; m_code = 3; end
        default: if (cmd_ack) ms = 0;
      endcase
      if (popq) void'(hq.pop_front());
      if (pushq) hq.push_back(int'(irq_in_id));
      if (wr_ok) begin m_b31 = reg_wdata[31]; m_b0 = reg_wdata[0]; end
    end
  end

  // every-cycle comparison, mid-cycle
  always @(negedge clk) if (rst_n) begin
    bit ev;
    ev = (ms == 0) && (hq.size() > 0 || irq_in_valid);
    chk("R4/R5 cmd_valid", cmd_valid, m_issue);
    if (m_issue) chk("R4/R5 cmd_code", cmd_code, m_code);
    chk("R6/R8 irq_out_valid", irq_out_valid, ev);
    if (ev) chk("R8 irq_out_id", irq_out_id, hq.size() > 0 ? hq[0] : irq_in_id);
    chk("R9 irq_in_ready", irq_in_ready, m_in_ready());
    chk("R7 wake_req", wake_req, m_wake);
    chk("R10 proto_err", proto_err, m_err);
    chk("R2/R3 reg_rdata", reg_rdata, m_rdata());
  end

  // output ready pattern and forwarded-id log
  always @(posedge clk) begin
    #1 irq_out_ready = rdy_rand ? 1'($urandom) : 1'b1;
  end
  int unsigned got[$];
  always @(negedge clk) if (rst_n && irq_out_valid && irq_out_ready) got.push_back(int'(irq_out_id));

  // acknowledge responder
  initial forever begin
    @(negedge clk);
    if (auto_ack && cmd_valid) begin
      repeat (ack_lat) @(posedge clk);
      #1 cmd_ack = 1'b1;
      @(posedge clk);
      #1 cmd_ack = 1'b0;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(logic [15:0] a, logic [31:0] d, bit ns);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d; reg_nonsec = ns;
    tick(1);
    reg_valid = 0; reg_write = 0; reg_nonsec = 0;
  endtask

  task automatic reg_rd(logic [15:0] a, bit ns, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a; reg_nonsec = ns;
    @(negedge clk);
    d = reg_rdata;
    tick(1);
    reg_valid = 0; reg_nonsec = 0;
  endtask

  task automatic send(int id);
    bit hs;
    irq_in_valid = 1; irq_in_id = ID_W'(id);
    do begin
      @(negedge clk);
      hs = irq_in_ready;
      @(posedge clk);
    end while (!hs);
    #1 irq_in_valid = 0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned exp_ids[$];
    tick(3);
    rst_n = 1;
    tick(1);

    // R1: reset state
    reg_rd(OFS, 0, d);
    chk("R1 reset word", d, 32'h6);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 proto_err", proto_err, 0);

    // R11: stray ack while asleep
    cmd_ack = 1; tick(1); cmd_ack = 0; tick(1);
    reg_rd(OFS, 0, d);
    chk("R11 ack while asleep", d, 32'h6);

    // R5: wake up
    auto_ack = 1;
    reg_wr(OFS, 32'h0, 0);
    chk("R5 enable pulse", {cmd_valid, cmd_code}, 3'b111);
    reg_rd(OFS, 0, d);
    chk("R5 bits cleared", d, 32'h0);
    tick(6);

    // R11: stray ack while awake
    cmd_ack = 1; tick(1); cmd_ack = 0;
    reg_rd(OFS, 0, d);
    chk("R11 ack while awake", d, 32'h0);

    // R3: security gating
    reg_wr(OFS, 32'h8000_0000, 0);
    sec_disable = 0;
    reg_rd(OFS, 1, d);
    chk("R3 nonsec read zero", d, 32'h0);
    reg_wr(OFS, 32'h0000_0003, 1);
    reg_rd(OFS, 0, d);
    chk("R3 nonsec write ignored", d, 32'h8000_0000);
    sec_disable = 1;
    reg_wr(OFS, 32'hFFFF_FFFD, 1);
    reg_rd(OFS, 1, d);
    chk("R2 R3 storage bits, reserved zero", d, 32'h8000_0001);

    // R2: other offset
    reg_wr(16'h0010, 32'h0, 0);
    reg_rd(OFS, 0, d);
    chk("R2 other offset write no effect", d, 32'h8000_0001);
    reg_rd(16'h0010, 0, d);
    chk("R2 other offset reads zero", d, 32'h0);

    // R8: pass-through under back-pressure
    rdy_rand = 1;
    for (int i = 1; i <= 5; i++) send(i);
    tick(3);

    // R4/R10: sleep entry with an illegal clear in the middle
    rdy_rand = 0;
    reg_wr(OFS, 32'h8000_0003, 0);
    chk("R4 release pulse", {cmd_valid, cmd_code}, 3'b101);
    reg_wr(OFS, 32'h8000_0001, 0);
    chk("R10 proto_err pulse", proto_err, 1);
    reg_rd(OFS, 0, d);
    chk("R10 sleep bit kept", d, 32'h8000_0003);
    chk("R10 proto_err single", proto_err, 0);
    for (int i = 0; i < 40; i++) begin
      reg_rd(OFS, 0, d);
      if (d[2]) break;
    end
    chk("R4 asleep reached", d, 32'h8000_0007);

    // R6/R7/R9: hold while asleep
    for (int i = 0; i < DEPTH; i++) begin send(10 + i); exp_ids.push_back(10 + i); end
    @(negedge clk);
    chk("R7 wake raised", wake_req, 1);
    chk("R6 nothing forwarded", irq_out_valid, 0);
    irq_in_valid = 1; irq_in_id = ID_W'(99);
    @(negedge clk);
    chk("R9 full stalls input", irq_in_ready, 0);
    tick(1);
    irq_in_valid = 0;

    // R5/R7/R10: wake, stray sleep write during re-enable
    got.delete();
    rdy_rand = 1;
    reg_wr(OFS, 32'h0, 0);
    chk("R7 wake dropped", wake_req, 0);
    reg_wr(OFS, 32'h2, 0);
    reg_rd(OFS, 0, d);
    chk("R10 sleep write ignored while waking", d, 32'h0);
    send(50); exp_ids.push_back(50);
    send(51); exp_ids.push_back(51);
    tick(40);
    chk("R8 drained count", got.size(), exp_ids.size());
    for (int i = 0; i < exp_ids.size() && i < got.size(); i++)
      chk("R8 arrival order", got[i], exp_ids[i]);

    tick(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule